// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It walks a two-level translation table held in ordinary memory. Software first loads a directory base register, normally when it switches processes. After that, each request accepted on a valid/ready port starts a walk.

A walk makes two word reads in turn over a plain request/response memory port. The first read fetches a directory entry, which names a page table. The second read fetches a page table entry, which names a page frame. The block then joins the frame with the page offset of the linear address. Bit 0 of each entry marks it present. A clear present bit at either level ends the walk early, with a fault and an indication of which level failed. Only one memory read is outstanding at any time, and one walk runs at a time.

Top module: `xlat_walker`

## Requirements
- R1: While reset is applied and in the first cycles after it, req_ready is 1, mem_req_valid is 0 and res_valid is 0.
- R2: The first read of a walk goes to the directory base plus 4 times the directory index. The directory base is the loaded register value with its low 12 bits forced to zero. The directory index is linear address bits 31:22.
- R3: The second read goes to the directory entry with its low 12 bits forced to zero, plus 4 times the table index. The table index is linear address bits 21:12.
- R4: A walk that finds both entries present gives res_valid high for exactly one cycle. In that cycle res_fault is 0 and res_paddr is the page table entry bits 31:12 joined with linear address bits 11:0.
- R5: A directory entry whose bit 0 is 0 ends the walk after one read. The result then has res_fault = 1 and res_fault_lvl = 0.
- R6: A page table entry whose bit 0 is 0 ends the walk with res_fault = 1 and res_fault_lvl = 1.
- R7: Only one read is outstanding at a time. An unaccepted mem_req_valid stays high with a stable address until mem_req_ready is seen. req_ready stays 0 for the whole walk.
- R8: A load of the directory base register has no effect on the walk that is in progress. This also holds for a load made in the same cycle as a request is accepted. The new value is used from the next accepted request onward.
- R9: A faulting result reports res_paddr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| root_ld | input | 1 | Load strobe for the directory base register |
| root_wdata | input | 32 | New directory base value (low 12 bits are dropped) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_vaddr | input | 32 | Linear address to translate |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data (entry) |
| res_valid | output | 1 | One-cycle pulse: translation result available |
| res_paddr | output | 32 | Physical address (0 on a fault) |
| res_fault | output | 1 | Walk ended on a non-present entry |
| res_fault_lvl | output | 1 | Level that faulted: 0 directory, 1 table |

## Verification
The bench builds the block with its default widths: a 32-bit address, a 10-bit table index and a 12-bit offset. With these widths the sample address 0x08147258 splits into directory index 32, table index 0x147 and offset 0x258. The same widths put the extreme indices 0 and 1023 within reach, so the bench can check address generation at both ends of each table. A bench memory that can withhold its request grant lets the bench hold a walk mid-flight. This is how it checks the held read request and reloads of the directory base during a walk.

// File: rtl/xw_pkg.sv
package xw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DIR_REQ  = 3'd1,
    ST_DIR_WAIT = 3'd2,
    ST_TBL_REQ  = 3'd3,
    ST_TBL_WAIT = 3'd4,
    ST_DONE     = 3'd5
  } walk_state_e;

  typedef enum logic {
    LVL_DIR = 1'b0,
    LVL_TBL = 1'b1
  } walk_lvl_e;

endpackage

// File: rtl/xw_rst_sync.sv
module xw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/xw_root_reg.sv
module xw_root_reg #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_val,
  output logic [ADDR_W-1:0] root_base
);

  localparam int FRAME_W = ADDR_W - OFF_W;

  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_d;

  always_comb begin
    frame_d = frame_q;
    if (ld_en) frame_d = ld_val[ADDR_W-1:OFF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_d;
  end

  assign root_base = {frame_q, {OFF_W{1'b0}}};

endmodule

// File: rtl/xw_addr_gen.sv
module xw_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 12,
  parameter int IDX_W    = 10,
  parameter int ENT_LOG2 = 2
) (
  input  logic              lvl_tbl,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] ent_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] next_base,
  output logic [ADDR_W-1:0] pa_join
);

  localparam int DIX_W   = ADDR_W - OFF_W - IDX_W;
  localparam int DIR_LSB = OFF_W + IDX_W;
  localparam int DPAD_W  = ADDR_W - DIX_W - ENT_LOG2;
  localparam int TPAD_W  = ADDR_W - IDX_W - ENT_LOG2;

  logic [DIX_W-1:0]  dir_idx;
  logic [IDX_W-1:0]  tbl_idx;
  logic [ADDR_W-1:0] dir_off;
  logic [ADDR_W-1:0] tbl_off;

  assign dir_idx = vaddr[DIR_LSB +: DIX_W];
  assign tbl_idx = vaddr[OFF_W +: IDX_W];

  assign dir_off = {{DPAD_W{1'b0}}, dir_idx, {ENT_LOG2{1'b0}}};
  assign tbl_off = {{TPAD_W{1'b0}}, tbl_idx, {ENT_LOG2{1'b0}}};

  always_comb begin
    if (lvl_tbl) rd_addr = tbl_base + tbl_off;
    else         rd_addr = dir_base + dir_off;
  end

  assign next_base = {ent_data[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign pa_join   = {ent_data[ADDR_W-1:OFF_W], vaddr[OFF_W-1:0]};

endmodule

// File: rtl/xw_walk_ctrl.sv
module xw_walk_ctrl
  import xw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] root_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic [ADDR_W-1:0] next_base,
  input  logic [ADDR_W-1:0] pa_join,
  output logic              lvl_tbl,
  output logic [ADDR_W-1:0] vaddr_q,
  output logic [ADDR_W-1:0] dir_base_q,
  output logic [ADDR_W-1:0] tbl_base_q,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_paddr,
  output logic              res_fault,
  output logic              res_fault_lvl
);

  walk_state_e state_q, state_d;

  logic              present;
  logic              accept;
  logic              dir_hit;
  logic              res_en;
  logic [ADDR_W-1:0] vaddr_d, dir_base_d, tbl_base_d;
  logic [ADDR_W-1:0] paddr_d;
  logic              fault_d, lvl_d;
  logic [ADDR_W-1:0] paddr_q;
  logic              fault_q, lvl_q;

  assign present = mem_rsp_data[0];
  assign accept  = req_valid && (state_q == ST_IDLE);
  assign dir_hit = (state_q == ST_DIR_WAIT) && mem_rsp_valid && present;
  assign res_en  = ((state_q == ST_DIR_WAIT) && mem_rsp_valid && !present) ||
                   ((state_q == ST_TBL_WAIT) && mem_rsp_valid);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid)     state_d = ST_DIR_REQ;
      ST_DIR_REQ:  if (mem_req_ready) state_d = ST_DIR_WAIT;
      ST_DIR_WAIT: if (mem_rsp_valid) state_d = present ? ST_TBL_REQ : ST_DONE;
      ST_TBL_REQ:  if (mem_req_ready) state_d = ST_TBL_WAIT;
      ST_TBL_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
      ST_DONE:                        state_d = ST_IDLE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    vaddr_d    = vaddr_q;
    dir_base_d = dir_base_q;
    tbl_base_d = tbl_base_q;
    paddr_d    = paddr_q;
    fault_d    = fault_q;
    lvl_d      = lvl_q;
    if (accept) begin
      vaddr_d    = req_vaddr;
      dir_base_d = root_base;
    end
    if (dir_hit) tbl_base_d = next_base;
    if (res_en) begin
      fault_d = !present;
      lvl_d   = (state_q == ST_TBL_WAIT) ? LVL_TBL : LVL_DIR;
      paddr_d = present ? pa_join : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      vaddr_q    <= '0;
      dir_base_q <= '0;
      tbl_base_q <= '0;
      paddr_q    <= '0;
      fault_q    <= 1'b0;
      lvl_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      vaddr_q    <= vaddr_d;
      dir_base_q <= dir_base_d;
      tbl_base_q <= tbl_base_d;
      paddr_q    <= paddr_d;
      fault_q    <= fault_d;
      lvl_q      <= lvl_d;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
  assign lvl_tbl       = (state_q == ST_TBL_REQ) || (state_q == ST_TBL_WAIT);
  assign res_valid     = (state_q == ST_DONE);
  assign res_paddr     = paddr_q;
  assign res_fault     = fault_q;
  assign res_fault_lvl = lvl_q;

  // R7: a single outstanding read; request held until granted
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid)
    else $error("p_req_hold_r7");

  p_one_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid)
    else $error("p_one_outstanding_r7");

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready)
    else $error("p_busy_r7");

  // R8: the base snapshot cannot move while a walk is running
  p_base_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(dir_base_q))
    else $error("p_base_frozen_r8");

  // R9: faulting results carry a zero address
  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_paddr == '0))
    else $error("p_fault_zero_r9");

  // R4: a good result keeps the page offset
  p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fault) |-> (res_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]))
    else $error("p_offset_r4");

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 12,
  parameter int IDX_W       = 10,
  parameter int ENT_LOG2    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_ld,
  input  logic [ADDR_W-1:0] root_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_paddr,
  output logic              res_fault,
  output logic              res_fault_lvl
);

  logic              rst_n_s;
  logic [ADDR_W-1:0] root_base;
  logic              lvl_tbl;
  logic [ADDR_W-1:0] vaddr_q, dir_base_q, tbl_base_q;
  logic [ADDR_W-1:0] next_base, pa_join;

  xw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_s)
  );

  xw_root_reg #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_root (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ld_en     (root_ld),
    .ld_val    (root_wdata),
    .root_base (root_base)
  );

  xw_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_LOG2(ENT_LOG2)) u_agen (
    .lvl_tbl   (lvl_tbl),
    .vaddr     (vaddr_q),
    .dir_base  (dir_base_q),
    .tbl_base  (tbl_base_q),
    .ent_data  (mem_rsp_data),
    .rd_addr   (mem_req_addr),
    .next_base (next_base),
    .pa_join   (pa_join)
  );

  xw_walk_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_ready     (req_ready),
    .root_base     (root_base),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .next_base     (next_base),
    .pa_join       (pa_join),
    .lvl_tbl       (lvl_tbl),
    .vaddr_q       (vaddr_q),
    .dir_base_q    (dir_base_q),
    .tbl_base_q    (tbl_base_q),
    .res_valid     (res_valid),
    .res_paddr     (res_paddr),
    .res_fault     (res_fault),
    .res_fault_lvl (res_fault_lvl)
  );

  // R2/R3: every entry read is word aligned
  p_addr_align_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_req_valid |-> (mem_req_addr[ENT_LOG2-1:0] == '0))
    else $error("p_addr_align_r2");

  // R7: address held while the request waits
  p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr))
    else $error("p_addr_stable_r7");

  // R4: result valid is a single-cycle pulse
  p_res_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_valid |=> !res_valid)
    else $error("p_res_pulse_r4");

endmodule

// File: tb/sim_xlat_walker.sv
module sim_xlat_walker;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        root_ld;
  logic [31:0] root_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        res_valid;
  logic [31:0] res_paddr;
  logic        res_fault;
  logic        res_fault_lvl;

  int n_tests;
  int n_fail;
  bit finished;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [0:63];
  int          rd_cnt;
  int          res_cnt;
  logic [31:0] got_pa;
  logic        got_fault;
  logic        got_lvl;

  xlat_walker u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .root_ld       (root_ld),
    .root_wdata    (root_wdata),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .res_valid     (res_valid),
    .res_paddr     (res_paddr),
    .res_fault     (res_fault),
    .res_fault_lvl (res_fault_lvl)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: answers one cycle after a granted request
  initial begin
    rd_cnt = 0;
    res_cnt = 0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
  end

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
      rd_log[rd_cnt % 64] <= mem_req_addr;
      rd_cnt <= rd_cnt + 1;
    end else begin
      mem_rsp_valid <= 1'b0;
    end
    if (res_valid) begin
      got_pa    <= res_paddr;
      got_fault <= res_fault;
      got_lvl   <= res_fault_lvl;
      res_cnt   <= res_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic load_root(input logic [31:0] v);
    @(negedge clk);
    root_ld = 1'b1;
    root_wdata = v;
    @(negedge clk);
    root_ld = 1'b0;
  endtask

  task automatic start_req(input logic [31:0] v, input bit with_ld, input logic [31:0] rv);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = v;
    root_ld = with_ld;
    root_wdata = rv;
    @(negedge clk);
    req_valid = 1'b0;
    root_ld = 1'b0;
  endtask

  task automatic wait_result(input int r0);
    int guard = 0;
    while (res_cnt == r0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic check_result(input string req, input int c0, input int nrd,
                              input logic [31:0] dir_a, input logic [31:0] tbl_a,
                              input bit fault, input bit lvl, input logic [31:0] pa);
    check(rd_cnt - c0 == nrd, {req, " read count"}, rd_cnt - c0, nrd);
    check(rd_log[c0 % 64] == dir_a, {req, " directory read address"}, rd_log[c0 % 64], dir_a);
    if (nrd == 2)
      check(rd_log[(c0 + 1) % 64] == tbl_a, {req, " table read address"}, rd_log[(c0 + 1) % 64], tbl_a);
    check(got_fault == fault, {req, " fault flag"}, 32'(got_fault), 32'(fault));
    if (fault)
      check(got_lvl == lvl, {req, " fault level"}, 32'(got_lvl), 32'(lvl));
    check(got_pa == pa, {req, " physical address"}, got_pa, pa);
  endtask

  task automatic do_walk(input string req, input logic [31:0] v, input int nrd,
                         input logic [31:0] dir_a, input logic [31:0] tbl_a,
                         input bit fault, input bit lvl, input logic [31:0] pa);
    int c0 = rd_cnt;
    int r0 = res_cnt;
    start_req(v, 1'b0, '0);
    wait_result(r0);
    check(res_cnt == r0 + 1, {req, " one result pulse"}, res_cnt - r0, 1);
    check_result(req, c0, nrd, dir_a, tbl_a, fault, lvl, pa);
  endtask

  // R1
  task automatic t_reset();
    rst_n = 1'b0;
    root_ld = 1'b0;
    root_wdata = '0;
    req_valid = 1'b0;
    req_vaddr = '0;
    mem_req_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 req_ready in reset", 32'(req_ready), 1);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid in reset", 32'(mem_req_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 1);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", 32'(mem_req_valid), 0);
    check(res_valid == 1'b0, "R1 res_valid after reset", 32'(res_valid), 0);
  endtask

  // R2 R3 R4: sample address, base with low bits set (masked)
  task automatic t_basic();
    load_root(32'h0010_0ABC);
    do_walk("R2 R3 R4 basic", 32'h0814_7258, 2, 32'h0010_0080, 32'h0020_051C,
            1'b0, 1'b0, 32'h1234_5258);
  endtask

  // R2 R3 R4: index extremes
  task automatic t_extremes();
    do_walk("R2 R3 R4 top indices", 32'hFFFF_FFFF, 2, 32'h0010_0FFC, 32'h7FFF_FFFC,
            1'b0, 1'b0, 32'hABCD_EFFF);
    do_walk("R2 R3 R4 zero indices", 32'h0000_0000, 2, 32'h0010_0000, 32'h0040_0000,
            1'b0, 1'b0, 32'h0000_0000);
  endtask

  // R5 R9
  task automatic t_dir_fault();
    do_walk("R5 R9 directory fault", 32'h00C0_0123, 1, 32'h0010_000C, 32'h0,
            1'b1, 1'b0, 32'h0);
  endtask

  // R6 R9
  task automatic t_tbl_fault();
    do_walk("R6 R9 table fault", 32'h0814_8000, 2, 32'h0010_0080, 32'h0020_0520,
            1'b1, 1'b1, 32'h0);
  endtask

  // R7: grant withheld
  task automatic t_backpressure();
    int c0 = rd_cnt;
    int r0 = res_cnt;
    mem_req_ready = 1'b0;
    start_req(32'h0814_7258, 1'b0, '0);
    repeat (5) @(negedge clk);
    check(mem_req_valid == 1'b1, "R7 request held", 32'(mem_req_valid), 1);
    check(mem_req_addr == 32'h0010_0080, "R7 address held", mem_req_addr, 32'h0010_0080);
    check(req_ready == 1'b0, "R7 busy while walking", 32'(req_ready), 0);
    check(rd_cnt == c0, "R7 no read issued without grant", rd_cnt - c0, 0);
    mem_req_ready = 1'b1;
    wait_result(r0);
    check_result("R7 completes after stall", c0, 2, 32'h0010_0080, 32'h0020_051C,
                 1'b0, 1'b0, 32'h1234_5258);
  endtask

  // R8: base reload during a walk and in the accept cycle
  task automatic t_root_reload();
    int c0 = rd_cnt;
    int r0 = res_cnt;
    mem_req_ready = 1'b0;
    start_req(32'h0814_7258, 1'b0, '0);
    load_root(32'h0030_0000);
    mem_req_ready = 1'b1;
    wait_result(r0);
    check_result("R8 reload mid walk ignored", c0, 2, 32'h0010_0080, 32'h0020_051C,
                 1'b0, 1'b0, 32'h1234_5258);
    do_walk("R8 new base used next", 32'h0814_7258, 2, 32'h0030_0080, 32'h0060_051C,
            1'b0, 1'b0, 32'h0ABC_D258);
    c0 = rd_cnt;
    r0 = res_cnt;
    start_req(32'h0814_7258, 1'b1, 32'h0010_0000);
    wait_result(r0);
    check_result("R8 same-cycle reload ignored", c0, 2, 32'h0030_0080, 32'h0060_051C,
                 1'b0, 1'b0, 32'h0ABC_D258);
    do_walk("R8 same-cycle reload used next", 32'h0814_7258, 2, 32'h0010_0080, 32'h0020_051C,
            1'b0, 1'b0, 32'h1234_5258);
  endtask

  initial begin
    n_tests = 0;
    n_fail = 0;
    finished = 1'b0;
    mem[32'h0010_0080] = 32'h0020_0ABD;
    mem[32'h0020_051C] = 32'h1234_5FFF;
    mem[32'h0010_0FFC] = 32'h7FFF_F001;
    mem[32'h7FFF_FFFC] = 32'hABCD_E001;
    mem[32'h0010_0000] = 32'h0040_0003;
    mem[32'h0040_0000] = 32'h0000_0001;
    mem[32'h0010_000C] = 32'h0050_0FFE;
    mem[32'h0020_0520] = 32'h9999_9FFE;
    mem[32'h0030_0080] = 32'h0060_0001;
    mem[32'h0060_051C] = 32'h0ABC_D001;
    t_reset();
    t_basic();
    t_extremes();
    t_dir_fault();
    t_tbl_fault();
    t_backpressure();
    t_root_reload();
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule